// File: doc/BRIEF.md
# SPI Serial Memory Slave Controller

This block is the slave-side command engine for a byte-addressable memory reached over SPI (mode 0 only). It runs on the system clock and oversamples the serial pins. It decodes a one-byte opcode. For array transfers it collects a three-byte address and then moves data in bursts through a byte-wide memory port that covers 2^AW locations (128K by default).

A small status register holds the write-enable latch, two block-protect bits, a protect-enable bit and a live busy flag. Writes to the array and to the status register are gated by the latch, by the block-protect range and by a hardware write-protect pin. A busy input tells the block that a nonvolatile store or recall is under way. While it is high, array reads and writes are refused.

Top module: `spi_mem_slave`

## Requirements
- R1: A frame begins when `spi_cs_n` falls. SI is sampled on rising `spi_sck` and SO changes after falling `spi_sck`, with every byte sent MSB first. The opcodes are 0x06 set-enable, 0x04 clear-enable, 0x05 status read, 0x01 status write, 0x03 read and 0x02 write.
- R2: A read is 0x03 followed by three address bytes. The first byte supplies only address bit 16 (in its bit 0), and its other seven bits are ignored. The next two bytes give bits 15..8 and 7..0. Data starts MSB first on the first falling SCK edge after the last address bit, and SI during the data phase is ignored.
- R3: While `spi_cs_n` stays low, a read or write burst moves to the next address after each byte, and the address wraps from 0x1FFFF to 0x00000.
- R4: A write (0x02) is accepted only if the write-enable latch is 1. Each complete data byte after the address produces exactly one `mem_wr` strobe, at successive addresses.
- R5: 0x06 sets the write-enable latch and 0x04 clears it. The latch is also cleared when `spi_cs_n` rises after an accepted write.
- R6: When `nv_busy` is high as a read or write opcode completes, that command is refused. The refused command makes no memory access for the rest of the frame, SO stays 0, and the write-enable latch is unchanged.
- R7: A status read returns {protect-enable, 0, 0, 0, BP[1], BP[0], write-enable, busy} with bit 7 first. The byte repeats for as long as clocks continue.
- R8: The first byte after a status write loads protect-enable from bit 7 and BP from bits 3:2. This happens only when write-enable is 1 and the command is not blocked; a command is blocked when protect-enable is 1 and `wp_n` is low. The permission is fixed when the opcode completes, so `wp_n` falling later in the frame does not cancel it.
- R9: BP selects the protected range: 00 none, 01 addresses with bits 16:15 = 11, 10 addresses with bit 16 = 1, 11 the whole array. A byte aimed at a protected address gets no strobe, but the burst address still advances.
- R10: A byte cut short by `spi_cs_n` rising is discarded. An unknown opcode makes the rest of its frame have no effect.
- R11: After reset the status register reads 0x00, SO is 0 and no memory strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCK |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_si | input | 1 | Serial data in |
| spi_so | output | 1 | Serial data out, 0 when idle |
| wp_n | input | 1 | Hardware write-protect pin, low means protect |
| nv_busy | input | 1 | Nonvolatile store/recall in progress, synchronous to clk |
| mem_addr | output | AW | Memory byte address |
| mem_rd | output | 1 | Read request, data expected one cycle later |
| mem_rdata | input | 8 | Read data |
| mem_wr | output | 1 | One-cycle write strobe |
| mem_wdata | output | 8 | Write data |

## Verification
The hardest case to reach from the ports is a status write whose permission was granted at the opcode while the protect pin falls before the data byte arrives. The bench first sets protect-enable with the pin high. It then issues the status-write opcode, pulls `wp_n` low between the opcode and the data byte, and confirms through a status read that the write landed. It repeats the sequence with the pin held low from the start and confirms the write was refused. Bursts are also driven across the top of the address space, and across the edges of each block-protect range, so that wrap and drop-but-advance behaviour show up in the scoreboard of write strobes.

// File: rtl/spi_mem_pkg.sv
// Shared opcodes and state encoding for the SPI memory slave.
// Assumes: single-byte opcodes, mode 0 framing.
package spi_mem_pkg;
    localparam logic [7:0] OPC_SR_WRITE = 8'h01;
    localparam logic [7:0] OPC_WRITE    = 8'h02;
    localparam logic [7:0] OPC_READ     = 8'h03;
    localparam logic [7:0] OPC_WE_CLR   = 8'h04;
    localparam logic [7:0] OPC_SR_READ  = 8'h05;
    localparam logic [7:0] OPC_WE_SET   = 8'h06;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_RDAT,
        ST_WDAT,
        ST_SRRD,
        ST_SRWR,
        ST_SKIP
    } cmd_state_t;
endpackage

// File: rtl/spi_mem_sync.sv
// Multi-stage synchronizer for asynchronous pins.
// Assumes: STAGES >= 1; each bit is synchronized on its own, without bus coherence.
module spi_mem_sync #(
    parameter int         W       = 4,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    generate
        if (STAGES == 1) begin : g_single
            logic [W-1:0] stg;
            // single flop stage
            always_ff @(posedge clk) begin
                if (!rst_n) stg <= RST_VAL;
                else        stg <= d_i;
            end
            assign q_o = stg;
        end else begin : g_chain
            logic [STAGES-1:0][W-1:0] stg;
            // shift chain of flop stages
            always_ff @(posedge clk) begin
                if (!rst_n) stg <= {STAGES{RST_VAL}};
                else        stg <= {stg[STAGES-2:0], d_i};
            end
            assign q_o = stg[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/spi_mem_guard.sv
// Protection decisions: block-protect range hit and status-write permission.
// Assumes: only the two top address bits select the protected range.
module spi_mem_guard (
    input  logic [1:0] bp_i,
    input  logic [1:0] a_top_i,
    input  logic       wel_i,
    input  logic       wpen_i,
    input  logic       wp_n_i,
    output logic       blk_hit_o,
    output logic       sr_ok_o
);
    // range decode from block-protect bits
    always_comb begin
        unique case (bp_i)
            2'b00:   blk_hit_o = 1'b0;
            2'b01:   blk_hit_o = &a_top_i;
            2'b10:   blk_hit_o = a_top_i[1];
            default: blk_hit_o = 1'b1;
        endcase
    end

    // status write allowed only with latch set and pin lock not active
    assign sr_ok_o = wel_i & ~(wpen_i & ~wp_n_i);
endmodule

// File: rtl/spi_mem_txshift.sv
// Output byte shifter driving SO; loads a byte and shifts one bit per falling SCK.
// Assumes: load and shift never coincide (they come from opposite SCK edges).
module spi_mem_txshift (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_i,
    input  logic       load_i,
    input  logic [7:0] load_val_i,
    input  logic       shift_i,
    output logic       so_o
);
    logic [7:0] tx;

    // shifter with clear > load > shift priority
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            tx   <= '0;
            so_o <= 1'b0;
        end else if (load_i) begin
            tx <= load_val_i;
        end else if (shift_i) begin
            so_o <= tx[7];
            tx   <= {tx[6:0], 1'b0};
        end
    end

    // SO only moves on a shift or clear (R2)
    p_so_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_i && !clr_i) |=> $stable(so_o));
endmodule

// File: rtl/spi_mem_slave.sv
// SPI mode-0 slave command engine for a byte-wide memory with status register
// and write protection. Oversamples SCK/CS/SI/WP on clk.
// Assumes: each SCK phase lasts at least SYNC_STAGES+3 clk cycles; nv_busy is
// synchronous to clk; memory returns read data one cycle after mem_rd.
module spi_mem_slave
    import spi_mem_pkg::*;
#(
    parameter int AW          = 17,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          spi_sck,
    input  logic          spi_cs_n,
    input  logic          spi_si,
    output logic          spi_so,
    input  logic          wp_n,
    input  logic          nv_busy,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    input  logic [7:0]    mem_rdata,
    output logic          mem_wr,
    output logic [7:0]    mem_wdata
);
    localparam int ASH_W = AW - 8;

    logic [3:0] pins_s;
    logic sck_l, cs_l, si_l, wp_l;
    logic sck_prev, cs_prev;

    spi_mem_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({wp_n, spi_si, spi_cs_n, spi_sck}),
        .q_o   (pins_s)
    );
    assign {wp_l, si_l, cs_l, sck_l} = pins_s;

    // edge history of SCK and CS
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_prev <= 1'b0;
            cs_prev  <= 1'b1;
        end else begin
            sck_prev <= sck_l;
            cs_prev  <= cs_l;
        end
    end

    logic sck_rise, sck_fall, cs_start, cs_end;
    assign sck_rise = !cs_l && sck_l && !sck_prev;
    assign sck_fall = !cs_l && !sck_l && sck_prev;
    assign cs_start = !cs_l && cs_prev;
    assign cs_end   = cs_l && !cs_prev;

    logic [2:0] bit_cnt;
    logic [6:0] rx_sh;
    logic [7:0] rx_byte;
    logic       byte_done;
    assign rx_byte   = {rx_sh, si_l};
    assign byte_done = sck_rise && (bit_cnt == 3'd7);

    // input bit counter and receive shifter, restarted each frame
    always_ff @(posedge clk) begin
        if (!rst_n || cs_start) begin
            bit_cnt <= '0;
            rx_sh   <= '0;
        end else if (sck_rise) begin
            bit_cnt <= bit_cnt + 3'd1;
            rx_sh   <= rx_byte[6:0];
        end
    end

    cmd_state_t     st;
    logic           wel, wpen, is_wr, wr_act, sr_ok, rd_pend;
    logic [1:0]     bp, abyte;
    logic [ASH_W-1:0] addr_sh;
    logic [AW-1:0]  addr, addr_full;
    logic           mem_rd_q, mem_wr_q;
    logic [AW-1:0]  mem_addr_q;
    logic [7:0]     mem_wdata_q;
    logic           blk_hit, sr_ok_now;
    logic [7:0]     status;

    assign addr_full = {addr_sh, rx_byte};
    assign status    = {wpen, 3'b000, bp, wel, nv_busy};

    spi_mem_guard u_guard (
        .bp_i      (bp),
        .a_top_i   (addr[AW-1 -: 2]),
        .wel_i     (wel),
        .wpen_i    (wpen),
        .wp_n_i    (wp_l),
        .blk_hit_o (blk_hit),
        .sr_ok_o   (sr_ok_now)
    );

    // command sequencer: decode, address capture, data phases, status updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= ST_IDLE;
            wel         <= 1'b0;
            wpen        <= 1'b0;
            bp          <= '0;
            is_wr       <= 1'b0;
            wr_act      <= 1'b0;
            sr_ok       <= 1'b0;
            abyte       <= '0;
            addr_sh     <= '0;
            addr        <= '0;
            mem_rd_q    <= 1'b0;
            mem_wr_q    <= 1'b0;
            mem_addr_q  <= '0;
            mem_wdata_q <= '0;
        end else begin
            mem_rd_q <= 1'b0;
            mem_wr_q <= 1'b0;
            if (cs_end) begin
                st     <= ST_IDLE;
                wr_act <= 1'b0;
                if (wr_act) wel <= 1'b0;
            end else if (cs_start) begin
                st    <= ST_CMD;
                abyte <= '0;
            end else if (byte_done) begin
                unique case (st)
                    ST_CMD: begin
                        case (rx_byte)
                            OPC_WE_SET: begin
                                wel <= 1'b1;
                                st  <= ST_SKIP;
                            end
                            OPC_WE_CLR: begin
                                wel <= 1'b0;
                                st  <= ST_SKIP;
                            end
                            OPC_SR_READ: st <= ST_SRRD;
                            OPC_SR_WRITE: begin
                                sr_ok <= sr_ok_now;
                                st    <= ST_SRWR;
                            end
                            OPC_READ: begin
                                is_wr <= 1'b0;
                                st    <= nv_busy ? ST_SKIP : ST_ADDR;
                            end
                            OPC_WRITE: begin
                                is_wr <= 1'b1;
                                if (!nv_busy && wel) begin
                                    wr_act <= 1'b1;
                                    st     <= ST_ADDR;
                                end else begin
                                    st <= ST_SKIP;
                                end
                            end
                            default: st <= ST_SKIP;
                        endcase
                    end
                    ST_ADDR: begin
                        addr_sh <= {addr_sh[AW-17:0], rx_byte};
                        abyte   <= abyte + 2'd1;
                        if (abyte == 2'd2) begin
                            if (is_wr) begin
                                addr <= addr_full;
                                st   <= ST_WDAT;
                            end else begin
                                mem_addr_q <= addr_full;
                                mem_rd_q   <= 1'b1;
                                addr       <= addr_full + 1'b1;
                                st         <= ST_RDAT;
                            end
                        end
                    end
                    ST_RDAT: begin
                        mem_addr_q <= addr;
                        mem_rd_q   <= 1'b1;
                        addr       <= addr + 1'b1;
                    end
                    ST_WDAT: begin
                        mem_addr_q  <= addr;
                        mem_wdata_q <= rx_byte;
                        mem_wr_q    <= !blk_hit;
                        addr        <= addr + 1'b1;
                    end
                    ST_SRWR: begin
                        if (sr_ok) begin
                            wpen <= rx_byte[7];
                            bp   <= rx_byte[3:2];
                        end
                        st <= ST_SKIP;
                    end
                    default: ;
                endcase
            end
        end
    end

    // marks the cycle when requested read data is on mem_rdata
    always_ff @(posedge clk) begin
        if (!rst_n) rd_pend <= 1'b0;
        else        rd_pend <= mem_rd_q;
    end

    logic       tx_load;
    logic [7:0] tx_val;
    assign tx_load = rd_pend ||
                     (byte_done && ((st == ST_CMD && rx_byte == OPC_SR_READ) || st == ST_SRRD));
    assign tx_val  = rd_pend ? mem_rdata : status;

    spi_mem_txshift u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (cs_l),
        .load_i     (tx_load),
        .load_val_i (tx_val),
        .shift_i    (sck_fall),
        .so_o       (spi_so)
    );

    assign mem_addr  = mem_addr_q;
    assign mem_rd    = mem_rd_q;
    assign mem_wr    = mem_wr_q;
    assign mem_wdata = mem_wdata_q;

    // one strobe per byte, never back to back (R4)
    p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> !mem_wr);
    // read and write requests never overlap (R4)
    p_rw_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
    // latch drops after an accepted write frame closes (R5)
    p_wel_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_end && wr_act) |=> !wel);
    // busy opcode never enters the address phase (R6)
    p_busy_refuse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && st == ST_CMD && nv_busy) |=> (st != ST_ADDR));
    // denied status write leaves the bits untouched (R8)
    p_sr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && st == ST_SRWR && !sr_ok) |=> $stable({wpen, bp}));
    // whole-array protect forbids any strobe (R9)
    p_full_prot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bp == 2'b11) |-> !mem_wr);
endmodule

// File: tb/test_spi_mem_slave.sv
`timescale 1ns/1ps
module test_spi_mem_slave;
    localparam int AW = 17;
    localparam int HP = 8;
    localparam int AMASK = (1 << AW) - 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_si = 1'b0, wp_n = 1'b1, nv_busy = 1'b0;
    logic spi_so, mem_rd, mem_wr;
    logic [AW-1:0] mem_addr;
    logic [7:0] mem_rdata = 8'h00, mem_wdata;

    always #2.5 clk = ~clk;

    spi_mem_slave #(.AW(AW)) i_spi_mem_slave (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_si(spi_si), .spi_so(spi_so), .wp_n(wp_n), .nv_busy(nv_busy),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;
    logic [7:0] dmem [int];
    logic [7:0] ref_mem [int];
    bit m_wel = 1'b0, m_wpen = 1'b0;
    logic [1:0] m_bp = 2'b00;

    typedef struct packed { logic [AW-1:0] a; logic [7:0] d; } wexp_t;
    wexp_t exp_q[$];

    function automatic logic [7:0] seed(int a);
        return 8'((a * 37) ^ (a >> 5) ^ 8'h5A);
    endfunction

    function automatic logic [7:0] refv(int a);
        return ref_mem.exists(a) ? ref_mem[a] : seed(a);
    endfunction

    function automatic bit bprot(int a);
        case (m_bp)
            2'b00:   return 1'b0;
            2'b01:   return ((a >> 15) & 3) == 3;
            2'b10:   return ((a >> 16) & 1) == 1;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [7:0] exp_status();
        return {m_wpen, 3'b000, m_bp, m_wel, nv_busy};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // memory model, one cycle read latency
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= dmem.exists(int'(mem_addr)) ? dmem[int'(mem_addr)] : seed(int'(mem_addr));
        if (mem_wr) dmem[int'(mem_addr)] = mem_wdata;
    end

    // scoreboard monitor: every write strobe must match the next expected item
    always @(negedge clk) begin
        wexp_t e;
        if (rst_n && mem_wr) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4", "unexpected write strobe", 32'(mem_addr), 32'hFFFFFFFF);
            end else begin
                e = exp_q.pop_front();
                chk(mem_addr == e.a && mem_wdata == e.d, "R4", "write addr/data",
                    {7'b0, mem_addr, mem_wdata}, {7'b0, e.a, e.d});
            end
        end
    end

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            spi_si = tx[i];
            wclk(HP);
            rx[i] = spi_so;
            spi_sck = 1'b1;
            wclk(HP);
            spi_sck = 1'b0;
        end
    endtask

    task automatic cs_begin();
        spi_cs_n = 1'b0;
        wclk(HP);
    endtask

    task automatic cs_finish();
        wclk(HP);
        spi_cs_n = 1'b1;
        wclk(3 * HP);
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] r;
        cs_begin(); xfer(op, r); cs_finish();
        if (op == 8'h06) m_wel = 1'b1;
        if (op == 8'h04) m_wel = 1'b0;
    endtask

    task automatic sr_check(input string req, input string what);
        logic [7:0] r;
        cs_begin(); xfer(8'h05, r); xfer(8'h00, r); cs_finish();
        chk(r == exp_status(), req, what, 32'(r), 32'(exp_status()));
    endtask

    task automatic wrsr(input logic [7:0] v, input bit drop_wp);
        logic [7:0] r;
        bit ok;
        ok = m_wel && !(m_wpen && !wp_n);
        cs_begin(); xfer(8'h01, r);
        if (drop_wp) wp_n = 1'b0;
        xfer(v, r); cs_finish();
        if (ok) begin m_wpen = v[7]; m_bp = v[3:2]; end
    endtask

    task automatic spi_read(input logic [23:0] araw, input int n, input string req);
        logic [7:0] r, e;
        int a;
        a = int'(araw[16:0]);
        cs_begin();
        xfer(8'h03, r); xfer(araw[23:16], r); xfer(araw[15:8], r); xfer(araw[7:0], r);
        for (int k = 0; k < n; k++) begin
            xfer(8'hA5, r);
            e = nv_busy ? 8'h00 : refv(a);
            chk(r == e, req, "read data byte", 32'(r), 32'(e));
            a = (a + 1) & AMASK;
        end
        cs_finish();
    endtask

    task automatic spi_write(input int a0, input int n, input logic [7:0] d0);
        logic [7:0] r, d;
        int a;
        bit acc;
        acc = m_wel && !nv_busy;
        a = a0;
        cs_begin();
        xfer(8'h02, r); xfer({7'b1011001, 1'(a0 >> 16)}, r);
        xfer(8'(a0 >> 8), r); xfer(8'(a0), r);
        for (int k = 0; k < n; k++) begin
            d = d0 + 8'(k * 17);
            if (acc && !bprot(a)) begin
                exp_q.push_back('{a: AW'(a), d: d});
                ref_mem[a] = d;
            end
            xfer(d, r);
            a = (a + 1) & AMASK;
        end
        cs_finish();
        if (acc) m_wel = 1'b0;
        chk(exp_q.size() == 0, "R4", "missing write strobes", 32'(exp_q.size()), 32'd0);
    endtask

    initial begin
        logic [7:0] r, r2;
        wclk(10);
        // R11: reset state at the ports
        chk(spi_so == 1'b0, "R11", "SO in reset", 32'(spi_so), 32'd0);
        chk(!mem_wr && !mem_rd, "R11", "strobes in reset", {30'b0, mem_wr, mem_rd}, 32'd0);
        rst_n = 1'b1;
        wclk(6);
        sr_check("R11", "status after reset");

        // R2: plain read, ignored upper address bits, SI ignored in data phase
        spi_read(24'h000010, 4, "R2");
        spi_read(24'hFE1234, 3, "R2");

        // R4: write refused without latch
        spi_write(32'h00100, 2, 8'h31);
        // R5: latch set and clear
        cmd1(8'h06); sr_check("R5", "latch set");
        cmd1(8'h04); sr_check("R5", "latch cleared by 0x04");

        // R4 / R5: accepted burst write then auto clear
        cmd1(8'h06);
        spi_write(32'h00200, 3, 8'h40);
        sr_check("R5", "latch cleared after write");
        spi_read(24'h000200, 3, "R4");

        // R3: wrap in write and read bursts
        cmd1(8'h06);
        spi_write(32'h1FFFE, 4, 8'h90);
        spi_read(24'h01FFFF, 3, "R3");
        spi_read(24'h01FFFD, 6, "R3");

        // R9: block protect ranges
        cmd1(8'h06); wrsr(8'h04, 1'b0); sr_check("R8", "BP=01 loaded");
        spi_write(32'h17FFE, 4, 8'hC0);
        spi_read(24'h017FFE, 4, "R9");
        cmd1(8'h06); wrsr(8'h08, 1'b0);
        spi_write(32'h0FFFF, 2, 8'h21);
        spi_read(24'h00FFFF, 2, "R9");
        cmd1(8'h06); wrsr(8'h0C, 1'b0);
        spi_write(32'h00005, 2, 8'h77);
        spi_read(24'h000005, 2, "R9");
        cmd1(8'h06); wrsr(8'h00, 1'b0); sr_check("R9", "BP restored");

        // R8: pin lock, latched permission, latch requirement
        wrsr(8'h80, 1'b0); sr_check("R8", "protect-enable set");
        wp_n = 1'b0; wclk(4);
        wrsr(8'h84, 1'b0); sr_check("R8", "status locked by pin");
        wp_n = 1'b1; wclk(4);
        wrsr(8'h84, 1'b1); sr_check("R8", "permission latched before pin fall");
        wrsr(8'h80, 1'b0); sr_check("R8", "refused while pin low");
        spi_write(32'h00400, 1, 8'h5C);
        spi_read(24'h000400, 1, "R8");
        wp_n = 1'b1; wclk(4);
        cmd1(8'h06); wrsr(8'h00, 1'b0); sr_check("R8", "cleared with pin high");
        cmd1(8'h04); wrsr(8'h0C, 1'b0); sr_check("R8", "refused without latch");

        // R6: busy refusal
        nv_busy = 1'b1;
        sr_check("R7", "busy bit visible");
        spi_read(24'h000200, 2, "R6");
        cmd1(8'h06);
        spi_write(32'h00600, 2, 8'h11);
        sr_check("R6", "latch kept after refused write");
        nv_busy = 1'b0;
        spi_read(24'h000600, 2, "R6");

        // R7: status repeats
        cs_begin(); xfer(8'h05, r); xfer(8'h00, r); xfer(8'hFF, r2); cs_finish();
        chk(r == exp_status() && r2 == r, "R7", "status repeat", {16'b0, r, r2}, {16'b0, exp_status(), exp_status()});

        // R10: partial byte discarded
        cs_begin();
        xfer(8'h02, r); xfer(8'h00, r); xfer(8'h03, r); xfer(8'h00, r);
        exp_q.push_back('{a: AW'(17'h00300), d: 8'h11});
        ref_mem[32'h300] = 8'h11;
        xfer(8'h11, r);
        for (int i = 7; i >= 4; i--) begin
            spi_si = i[0];
            wclk(HP); spi_sck = 1'b1; wclk(HP); spi_sck = 1'b0;
        end
        cs_finish();
        m_wel = 1'b0;
        chk(exp_q.size() == 0, "R10", "full byte written", 32'(exp_q.size()), 32'd0);
        spi_read(24'h000300, 2, "R10");

        // R10: unknown opcode ignores rest of frame
        cs_begin(); xfer(8'hAB, r); xfer(8'h06, r); cs_finish();
        sr_check("R10", "unknown opcode frame ignored");

        // R1: longer burst with varied data, MSB-first round trip
        cmd1(8'h06);
        spi_write(32'h0A5A0, 5, 8'h3C);
        spi_read(24'h00A5A0, 5, "R1");

        wclk(20);
        chk(exp_q.size() == 0, "R4", "scoreboard drained", 32'(exp_q.size()), 32'd0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        wclk(150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule